// File: doc/BRIEF.md
# Dual SERDES strobe generator

This block produces two load strobes for serializers that run in a fast I/O clock domain. Each strobe is a single-cycle pulse repeated every N fast cycles, where N is a divide ratio from 1 to 8 chosen at run time. A two-bit mode input decides the relation between the two channels. They can run side by side, or one channel can be made a copy of the other, delayed by exactly one fast cycle, so that two serializer groups load on neighbouring cycles.

Strobe generation is gated by the lock signal from the upstream clock source. While that signal is low, nothing is emitted and the counters stay cleared. When the build-time option `SYNC_EN` is set, the block samples a slow global clock in the fast domain. It restarts its divide counters on each detected rising edge of that clock, so the strobe always lands on the same fast cycle relative to the slow clock. The lock output goes high only once the incoming lock is high and this alignment has taken place. When `SYNC_EN` is clear, the generators start on the first locked cycle and the slow clock is ignored.

Top module: `dual_strobe_gen`

## Requirements
- R1: While `rst_n` is low, `strobe0_o`, `strobe1_o` and `lock_o` are 0.
- R2: Once aligned, the leading strobe is a one-cycle pulse every N fast cycles, where N = `div_i` + 1 (`div_i` = 0 means N = 1, and 7 means N = 8). The first pulse comes in the cycle right after the alignment edge.
- R3: With `mode_i` = 2'b00 (independent), each channel has its own counter and its own strobe. Both strobes pulse in the same cycles.
- R4: With `mode_i` = 2'b01 or 2'b11 (follow channel 0), `strobe1_o` equals `strobe0_o` of the previous fast cycle while the incoming lock is high.
- R5: With `mode_i` = 2'b10 (follow channel 1), `strobe0_o` equals `strobe1_o` of the previous fast cycle while the incoming lock is high.
- R6: In any cycle where `pll_locked_i` is 0, both strobes are 0. Counters and alignment are cleared at the next edge.
- R7: `lock_o` is 1 exactly when the block has been aligned since `pll_locked_i` last rose. It falls in the cycle after a clock edge that samples `pll_locked_i` low.
- R8: With `SYNC_EN` = 1, `gclk_in` passes through a two-stage synchronizer. The edge that samples `gclk_in` high for the third time after a low sample reloads the counters and sets alignment, so the leading strobe and `lock_o` go high in the following cycle. This happens on every such slow edge, not only the first.
- R9: With `SYNC_EN` = 0, alignment happens at the first edge that samples `pll_locked_i` high, and `gclk_in` has no effect.
- R10: With N = 1, the leading strobe is high in every cycle in which `lock_o` and `pll_locked_i` are both high.
- R11: After the incoming lock drops and returns, alignment restarts. With `SYNC_EN` = 1, `lock_o` stays low until the next detected slow-clock rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_io | input | 1 | Fast I/O clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gclk_in | input | 1 | Slow global clock, sampled as data |
| pll_locked_i | input | 1 | Lock indication from the clock source |
| mode_i | input | 2 | Channel relation: 00 independent, 01/11 ch1 follows ch0, 10 ch0 follows ch1 |
| div_i | input | CNT_W | Divide ratio minus one |
| strobe0_o | output | 1 | Channel 0 load strobe |
| strobe1_o | output | 1 | Channel 1 load strobe |
| lock_o | output | 1 | Qualified lock |

## Verification
The interesting collision is a slow-clock edge being detected in the same fast cycle that the incoming lock falls or rises. In that cycle, alignment, lock gating and the follower delay register all react at once. The bench sweeps a two-cycle lock drop across every offset of the slow-clock period, so the drop lands before, on and after the detected edge. A cycle-by-cycle behavioural model gives the expected strobe and lock values for both the synchronized and the free-running build, and these are compared with the outputs on every cycle.

// File: rtl/dual_strobe_gen.sv
module dual_strobe_gen #(
  parameter bit SYNC_EN = 1'b1,
  parameter int CNT_W   = 3
) (
  input  logic             clk_io,
  input  logic             rst_n,
  input  logic             gclk_in,
  input  logic             pll_locked_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] div_i,
  output logic             strobe0_o,
  output logic             strobe1_o,
  output logic             lock_o
);
  localparam logic [1:0] MODE_INDEP   = 2'b00;
  localparam logic [1:0] MODE_FOLLOW1 = 2'b10;
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [2:0]       gsync;
  logic             gclk_rise;
  logic             start;
  logic             aligned;
  logic [CNT_W-1:0] cnt0, cnt1;
  logic             raw0, raw1;
  logic             dly0, dly1;

  always_ff @(posedge clk_io or negedge rst_n)
    if (!rst_n) gsync <= '0;
    else        gsync <= {gsync[1:0], gclk_in};

  assign gclk_rise = gsync[1] & ~gsync[2];

  generate
    if (SYNC_EN) begin : g_sync
      assign start = gclk_rise;
    end else begin : g_free
      assign start = ~aligned;
    end
  endgenerate

  always_ff @(posedge clk_io or negedge rst_n) begin
    if (!rst_n) begin
      aligned <= 1'b0;
      cnt0    <= CNT_ZERO;
      cnt1    <= CNT_ZERO;
    end else if (!pll_locked_i) begin
      aligned <= 1'b0;
      cnt0    <= CNT_ZERO;
      cnt1    <= CNT_ZERO;
    end else if (start) begin
      aligned <= 1'b1;
      cnt0    <= CNT_ZERO;
      cnt1    <= CNT_ZERO;
    end else if (aligned) begin
      cnt0 <= (cnt0 >= div_i) ? CNT_ZERO : cnt0 + CNT_ONE;
      cnt1 <= (cnt1 >= div_i) ? CNT_ZERO : cnt1 + CNT_ONE;
    end
  end

  assign raw0 = pll_locked_i & aligned & (cnt0 == CNT_ZERO);
  assign raw1 = pll_locked_i & aligned & (cnt1 == CNT_ZERO);

  always_ff @(posedge clk_io or negedge rst_n)
    if (!rst_n) begin
      dly0 <= 1'b0;
      dly1 <= 1'b0;
    end else begin
      dly0 <= raw0;
      dly1 <= raw1;
    end

  always_comb begin
    case (mode_i)
      MODE_INDEP: begin
        strobe0_o = raw0;
        strobe1_o = raw1;
      end
      MODE_FOLLOW1: begin
        strobe0_o = pll_locked_i & dly1;
        strobe1_o = raw1;
      end
      default: begin
        strobe0_o = raw0;
        strobe1_o = pll_locked_i & dly0;
      end
    endcase
  end

  assign lock_o = aligned;
endmodule

// File: rtl/dual_strobe_gen_chk.sv
module dual_strobe_gen_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk_io,
  input logic             rst_n,
  input logic             pll_locked_i,
  input logic [1:0]       mode_i,
  input logic [CNT_W-1:0] div_i,
  input logic             strobe0_o,
  input logic             strobe1_o,
  input logic             lock_o
);
  // R6
  gate_off_chk: assert property (@(posedge clk_io) disable iff (!rst_n)
    !pll_locked_i |-> (!strobe0_o && !strobe1_o));

  // R7
  lock_drop_chk: assert property (@(posedge clk_io) disable iff (!rst_n)
    !pll_locked_i |=> !lock_o);

  // R7
  lock_rise_chk: assert property (@(posedge clk_io) disable iff (!rst_n)
    $rose(lock_o) |-> $past(pll_locked_i));

  // R2
  first_pulse_chk: assert property (@(posedge clk_io) disable iff (!rst_n)
    ($rose(lock_o) && pll_locked_i) |-> (strobe0_o || strobe1_o));

  // R3
  indep_eq_chk: assert property (@(posedge clk_io) disable iff (!rst_n)
    (mode_i == 2'b00) |-> (strobe0_o == strobe1_o));

  // R4
  follow0_chk: assert property (@(posedge clk_io) disable iff (!rst_n)
    (pll_locked_i && $past(pll_locked_i) && mode_i[0] && $stable(mode_i))
      |-> (strobe1_o == $past(strobe0_o)));

  // R5
  follow1_chk: assert property (@(posedge clk_io) disable iff (!rst_n)
    (pll_locked_i && $past(pll_locked_i) && mode_i == 2'b10 && $stable(mode_i))
      |-> (strobe0_o == $past(strobe1_o)));

  // R10
  div_one_chk: assert property (@(posedge clk_io) disable iff (!rst_n)
    (div_i == '0 && lock_o && pll_locked_i) |-> (strobe0_o || strobe1_o));
endmodule

bind dual_strobe_gen dual_strobe_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_io(clk_io), .rst_n(rst_n), .pll_locked_i(pll_locked_i),
  .mode_i(mode_i), .div_i(div_i), .strobe0_o(strobe0_o),
  .strobe1_o(strobe1_o), .lock_o(lock_o));

// File: tb/dual_strobe_gen_tb.sv
`timescale 1ns/1ps
module dual_strobe_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gclk = 1'b0;
  logic       lock_in = 1'b0;
  logic [1:0] mode = 2'b01;
  logic [2:0] div = 3'd1;
  logic       s0 [2];
  logic       s1 [2];
  logic       lk [2];

  always #2.5 clk = ~clk;

  dual_strobe_gen #(.SYNC_EN(1'b1), .CNT_W(3)) u_dut (
    .clk_io(clk), .rst_n(rst_n), .gclk_in(gclk), .pll_locked_i(lock_in),
    .mode_i(mode), .div_i(div), .strobe0_o(s0[0]), .strobe1_o(s1[0]), .lock_o(lk[0]));

  dual_strobe_gen #(.SYNC_EN(1'b0), .CNT_W(3)) u_dut_free (
    .clk_io(clk), .rst_n(rst_n), .gclk_in(gclk), .pll_locked_i(lock_in),
    .mode_i(mode), .div_i(div), .strobe0_o(s0[1]), .strobe1_o(s1[1]), .lock_o(lk[1]));

  int checks = 0;
  int fails = 0;
  int tick = 0;
  int gper = 8;
  bit done = 1'b0;
  bit al [2];
  int ph [2];
  bit dly [2];
  bit hist [$];

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at %0t: actual=%0b expected=%0b", tag, what, $time, act, exp);
    end
  endtask

  function automatic bit rawf(int i);
    return al[i] && lock_in && ph[i] == 0;
  endfunction

  task automatic model_edge();
    bit rise;
    rise = hist[1] && !hist[2];
    hist.push_front(gclk);
    void'(hist.pop_back());
    for (int i = 0; i < 2; i++) begin
      bit dn;
      bit st;
      dn = rawf(i);
      st = (i == 0) ? rise : !al[i];
      if (!lock_in) begin
        al[i] = 1'b0; ph[i] = 0;
      end else if (st) begin
        al[i] = 1'b1; ph[i] = 0;
      end else if (al[i]) begin
        ph[i] = (ph[i] + 1) % (int'(div) + 1);
      end
      dly[i] = dn;
    end
  endtask

  task automatic compare();
    for (int i = 0; i < 2; i++) begin
      bit r, e0, e1;
      string t0, t1;
      r = rawf(i);
      case (mode)
        2'b00: begin e0 = r; e1 = r; end
        2'b10: begin e0 = lock_in && dly[i]; e1 = r; end
        default: begin e0 = r; e1 = lock_in && dly[i]; end
      endcase
      if (i == 1) begin t0 = "R9"; t1 = "R9"; end
      else if (!lock_in) begin t0 = "R6"; t1 = "R6"; end
      else if (div == 3'd0) begin t0 = "R10"; t1 = "R10"; end
      else begin
        case (mode)
          2'b00: begin t0 = "R2 R8"; t1 = "R3"; end
          2'b10: begin t0 = "R5"; t1 = "R2 R8"; end
          default: begin t0 = "R2 R8"; t1 = "R4"; end
        endcase
      end
      chk(t0, i == 0 ? "strobe0 sync" : "strobe0 free", s0[i], e0);
      chk(t1, i == 0 ? "strobe1 sync" : "strobe1 free", s1[i], e1);
      chk(i == 0 ? "R7 R11" : "R7 R9", "lock_o", lk[i], al[i]);
    end
  endtask

  task automatic step(bit lkv);
    lock_in = lkv;
    gclk = ((tick % gper) >= gper / 2);
    tick++;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic run(logic [1:0] m, logic [2:0] d, int per, int lows, int highs);
    mode = m; div = d; gper = per;
    for (int k = 0; k < lows; k++) step(1'b0);
    for (int k = 0; k < highs; k++) step(1'b1);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin al[i] = 0; ph[i] = 0; dly[i] = 0; end
    repeat (3) hist.push_back(1'b0);
    lock_in = 1'b1;
    gclk = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      chk("R1", "strobe0 in reset", s0[i], 1'b0);
      chk("R1", "strobe1 in reset", s1[i], 1'b0);
      chk("R1", "lock_o in reset", lk[i], 1'b0);
    end
    lock_in = 1'b0;
    gclk = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    run(2'b01, 3'd1, 8, 5, 60);
    run(2'b01, 3'd1, 8, 3, 40);
    run(2'b00, 3'd3, 12, 2, 70);
    run(2'b10, 3'd7, 16, 2, 80);
    run(2'b00, 3'd0, 6, 2, 40);
    run(2'b11, 3'd4, 10, 2, 60);
    run(2'b01, 3'd2, 7, 2, 60);
    run(2'b10, 3'd1, 5, 2, 40);
    for (int off = 0; off < 8; off++) begin
      mode = 2'b01; div = 3'd3; gper = 8;
      for (int k = 0; k < off; k++) step(1'b1);
      step(1'b0);
      step(1'b0);
      for (int k = 0; k < 24; k++) step(1'b1);
    end
    for (int off = 0; off < 6; off++) begin
      mode = 2'b10; div = 3'd2; gper = 6;
      for (int k = 0; k < off; k++) step(1'b1);
      step(1'b0);
      for (int k = 0; k < 18; k++) step(1'b1);
    end
    run(2'b00, 3'd7, 16, 1, 50);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule